// File: doc/BRIEF.md
# Row-Checksum Memory Controller with Cross-Chip Parity Rebuild

This controller fronts a small set of data storage chips and one extra parity chip. All of them are modelled as on-chip arrays. Line addresses are interleaved across the data chips, so each line lives in exactly one row of exactly one chip. Every stored row carries a short checksum. A normal read touches only the array that holds the line and compares the checksum. When the comparison fails, the controller rebuilds the line by XOR from the same row of every other data chip and of the parity chip. It returns the rebuilt value with a corrected flag, or flags the response uncorrectable when one of those other rows is itself damaged.

A write is a read-modify-write. The controller reads the old line and the old parity row, then writes the new line and the new parity row. The new parity is the old parity XOR the old line XOR the new line, and both rows get a freshly computed checksum. The controller serves one request at a time and holds its ready low from acceptance until the response. A fault-injection port XORs a mask into the stored data of any row, including the parity chip's rows, without touching the stored checksum, so that error handling can be exercised.

Top module: `rowsum_parity_ctrl`

## Requirements
- R1: After reset, req_ready is 1 and resp_valid is 0, and every line reads back as zero with both flags low.
- R2: A line address selects the data chip with its low log2(CHIPS) bits and the row with its upper bits (CHIPS is a power of two). Each of the CHIPS*ROWS lines holds its own value independently.
- R3: A read of an undamaged line raises resp_valid after the first clock edge following acceptance, carrying the stored value with both flags low.
- R4: A write raises resp_valid after the third clock edge following acceptance, with both flags low, and a later read returns the written value.
- R5: req_ready is low from the edge that accepts a request until resp_valid rises. resp_valid is a single-cycle pulse and appears only while req_ready is high.
- R6: Each row's checksum is the XOR of its CSUM_W-bit slices. Any nonzero corruption confined to one slice of one row is detected on read.
- R7: On a detected mismatch, the response carries the XOR of the same row in the other data chips and the parity chip, with resp_corrected set. It arrives after CHIPS+2 edges following acceptance.
- R8: If any other row used in a rebuild (the parity row or another data chip's row) also fails its checksum, resp_uncorrectable is set and resp_corrected is clear.
- R9: After any sequence of writes, each parity row equals the XOR of its data rows, so every single-slice corruption of any line rebuilds to the last value written there.
- R10: resp_corrected and resp_uncorrectable are both low whenever resp_valid is low, and never high together.
- R11: inj_valid XORs inj_mask into the data of row inj_row on chip inj_chip (index CHIPS is the parity chip) and leaves its checksum unchanged. Damage to a parity row alone does not affect reads of data lines.
- R12: A rebuild does not write the array back. The damaged row stays damaged and is rebuilt again on every later read until it is repaired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Line address {row, chip} |
| req_wdata | input | WORD_W | Write data |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_rdata | output | WORD_W | Read data, rebuilt if corrected |
| resp_corrected | output | 1 | Line was rebuilt from parity |
| resp_uncorrectable | output | 1 | Rebuild failed, data not valid |
| inj_valid | input | 1 | Apply corruption mask this cycle |
| inj_chip | input | CIDX_W | Chip to corrupt, CHIPS = parity chip |
| inj_row | input | ROW_W | Row to corrupt |
| inj_mask | input | WORD_W | Bits to flip in the stored data |

## Verification
The assertions assume that inj_valid is pulsed only while the controller is idle with no request being accepted. They also assume that writes go only to lines whose own row and parity row are intact, since the incremental parity update would otherwise spread damage. The stimulus meets both conditions: each injection is a single cycle between transactions, and every injected mask is cancelled by re-applying it before any write follows. Corruption masks are always confined to one checksum slice, which is the only damage the checksum promises to catch.

// File: rtl/rcp_pkg.sv
package rcp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_REBUILD,
    ST_WOLD,
    ST_WPAR,
    ST_WPUT
  } rcp_state_e;

endpackage

// File: rtl/rcp_csum.sv
module rcp_csum #(
  parameter int WORD_W = 16,
  parameter int CSUM_W = 4
) (
  input  logic [WORD_W-1:0] data,
  output logic [CSUM_W-1:0] csum
);
  localparam int SLICES = WORD_W / CSUM_W;

  always_comb begin
    csum = '0;
    for (int s = 0; s < SLICES; s++) begin
      csum = csum ^ data[s*CSUM_W +: CSUM_W];
    end
  end
endmodule

// File: rtl/rcp_bank.sv
module rcp_bank #(
  parameter int CHIPS  = 4,
  parameter int ROWS   = 8,
  parameter int WORD_W = 16,
  parameter int CSUM_W = 4,
  parameter int ROW_W  = $clog2(ROWS),
  parameter int CIDX_W = $clog2(CHIPS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CIDX_W-1:0] rd_chip,
  input  logic [ROW_W-1:0]  rd_row,
  output logic [WORD_W-1:0] rd_data,
  output logic [CSUM_W-1:0] rd_csum,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic              dw_en,
  input  logic [CIDX_W-1:0] dw_chip,
  input  logic [WORD_W-1:0] dw_data,
  input  logic [CSUM_W-1:0] dw_csum,
  input  logic              pw_en,
  input  logic [WORD_W-1:0] pw_data,
  input  logic [CSUM_W-1:0] pw_csum,
  input  logic              inj_en,
  input  logic [CIDX_W-1:0] inj_chip,
  input  logic [ROW_W-1:0]  inj_row,
  input  logic [WORD_W-1:0] inj_mask
);
  localparam int ENT_W = WORD_W + CSUM_W;

  logic [ENT_W-1:0] rd_ent [CHIPS+1];
  logic [ENT_W-1:0] rd_sel;

  for (genvar c = 0; c <= CHIPS; c++) begin : g_chip
    logic [ENT_W-1:0]  mem_q [ROWS];
    logic              we;
    logic [WORD_W-1:0] wd;
    logic [CSUM_W-1:0] wc;
    logic              ie;

    if (c == CHIPS) begin : g_par
      assign we = pw_en;
      assign wd = pw_data;
      assign wc = pw_csum;
    end else begin : g_dat
      assign we = dw_en && (dw_chip == CIDX_W'(c));
      assign wd = dw_data;
      assign wc = dw_csum;
    end

    assign ie = inj_en && (inj_chip == CIDX_W'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int r = 0; r < ROWS; r++) begin
          mem_q[r] <= '0;
        end
      end else begin
        if (we) begin
          mem_q[wr_row] <= {wc, wd};
        end
        if (ie) begin
          mem_q[inj_row] <= mem_q[inj_row] ^ {{CSUM_W{1'b0}}, inj_mask};
        end
      end
    end

    assign rd_ent[c] = mem_q[rd_row];
  end

  always_comb begin
    rd_sel = '0;
    for (int c = 0; c <= CHIPS; c++) begin
      if (rd_chip == CIDX_W'(c)) begin
        rd_sel = rd_ent[c];
      end
    end
  end

  assign rd_data = rd_sel[WORD_W-1:0];
  assign rd_csum = rd_sel[ENT_W-1:WORD_W];
endmodule

// File: rtl/rowsum_parity_ctrl.sv
module rowsum_parity_ctrl
  import rcp_pkg::*;
#(
  parameter int CHIPS  = 4,
  parameter int ROWS   = 8,
  parameter int WORD_W = 16,
  parameter int CSUM_W = 4,
  parameter int CHIP_W = $clog2(CHIPS),
  parameter int ROW_W  = $clog2(ROWS),
  parameter int ADDR_W = CHIP_W + ROW_W,
  parameter int CIDX_W = $clog2(CHIPS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              resp_valid,
  output logic [WORD_W-1:0] resp_rdata,
  output logic              resp_corrected,
  output logic              resp_uncorrectable,
  input  logic              inj_valid,
  input  logic [CIDX_W-1:0] inj_chip,
  input  logic [ROW_W-1:0]  inj_row,
  input  logic [WORD_W-1:0] inj_mask
);
  rcp_state_e        state_q, state_d;
  logic [CHIP_W-1:0] chip_q, chip_d;
  logic [ROW_W-1:0]  row_q, row_d;
  logic [WORD_W-1:0] wdata_q, wdata_d;
  logic [WORD_W-1:0] old_q, old_d;
  logic [WORD_W-1:0] npar_q, npar_d;
  logic [WORD_W-1:0] acc_q, acc_d;
  logic [CIDX_W-1:0] idx_q, idx_d;
  logic              bad_q, bad_d;
  logic              rv_q, rv_d;
  logic [WORD_W-1:0] rdat_q, rdat_d;
  logic              corr_q, corr_d;
  logic              unc_q, unc_d;

  logic [CIDX_W-1:0] rd_chip;
  logic [CIDX_W-1:0] tgt_idx;
  logic [WORD_W-1:0] rd_data;
  logic [CSUM_W-1:0] rd_csum;
  logic [CSUM_W-1:0] rd_calc;
  logic [CSUM_W-1:0] wr_csum;
  logic [CSUM_W-1:0] par_csum;
  logic              rd_ok;
  logic              put_en;

  assign tgt_idx = CIDX_W'(chip_q);
  assign put_en  = (state_q == ST_WPUT);

  always_comb begin
    case (state_q)
      ST_REBUILD: rd_chip = idx_q;
      ST_WPAR:    rd_chip = CIDX_W'(CHIPS);
      default:    rd_chip = tgt_idx;
    endcase
  end

  rcp_bank #(
    .CHIPS(CHIPS), .ROWS(ROWS), .WORD_W(WORD_W), .CSUM_W(CSUM_W)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_chip  (rd_chip),
    .rd_row   (row_q),
    .rd_data  (rd_data),
    .rd_csum  (rd_csum),
    .wr_row   (row_q),
    .dw_en    (put_en),
    .dw_chip  (tgt_idx),
    .dw_data  (wdata_q),
    .dw_csum  (wr_csum),
    .pw_en    (put_en),
    .pw_data  (npar_q),
    .pw_csum  (par_csum),
    .inj_en   (inj_valid),
    .inj_chip (inj_chip),
    .inj_row  (inj_row),
    .inj_mask (inj_mask)
  );

  rcp_csum #(.WORD_W(WORD_W), .CSUM_W(CSUM_W)) u_rd_sum  (.data(rd_data), .csum(rd_calc));
  rcp_csum #(.WORD_W(WORD_W), .CSUM_W(CSUM_W)) u_wr_sum  (.data(wdata_q), .csum(wr_csum));
  rcp_csum #(.WORD_W(WORD_W), .CSUM_W(CSUM_W)) u_par_sum (.data(npar_q),  .csum(par_csum));

  assign rd_ok = (rd_calc == rd_csum);

  // next-state process
  always_comb begin
    state_d = state_q;
    chip_d  = chip_q;
    row_d   = row_q;
    wdata_d = wdata_q;
    old_d   = old_q;
    npar_d  = npar_q;
    acc_d   = acc_q;
    idx_d   = idx_q;
    bad_d   = bad_q;
    rv_d    = 1'b0;
    rdat_d  = rdat_q;
    corr_d  = 1'b0;
    unc_d   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          chip_d  = req_addr[CHIP_W-1:0];
          row_d   = req_addr[ADDR_W-1:CHIP_W];
          wdata_d = req_wdata;
          state_d = req_write ? ST_WOLD : ST_READ;
        end
      end
      ST_READ: begin
        if (rd_ok) begin
          rv_d    = 1'b1;
          rdat_d  = rd_data;
          state_d = ST_IDLE;
        end else begin
          idx_d   = '0;
          acc_d   = '0;
          bad_d   = 1'b0;
          state_d = ST_REBUILD;
        end
      end
      ST_REBUILD: begin
        if (idx_q != tgt_idx) begin
          acc_d = acc_q ^ rd_data;
          if (!rd_ok) begin
            bad_d = 1'b1;
          end
        end
        if (idx_q == CIDX_W'(CHIPS)) begin
          rv_d    = 1'b1;
          rdat_d  = acc_d;
          corr_d  = !bad_d;
          unc_d   = bad_d;
          state_d = ST_IDLE;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_WOLD: begin
        old_d   = rd_data;
        state_d = ST_WPAR;
      end
      ST_WPAR: begin
        npar_d  = rd_data ^ old_q ^ wdata_q;
        state_d = ST_WPUT;
      end
      ST_WPUT: begin
        rv_d    = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      chip_q  <= '0;
      row_q   <= '0;
      wdata_q <= '0;
      old_q   <= '0;
      npar_q  <= '0;
      acc_q   <= '0;
      idx_q   <= '0;
      bad_q   <= 1'b0;
      rv_q    <= 1'b0;
      rdat_q  <= '0;
      corr_q  <= 1'b0;
      unc_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      chip_q  <= chip_d;
      row_q   <= row_d;
      wdata_q <= wdata_d;
      old_q   <= old_d;
      npar_q  <= npar_d;
      acc_q   <= acc_d;
      idx_q   <= idx_d;
      bad_q   <= bad_d;
      rv_q    <= rv_d;
      rdat_q  <= rdat_d;
      corr_q  <= corr_d;
      unc_q   <= unc_d;
    end
  end

  assign req_ready          = (state_q == ST_IDLE);
  assign resp_valid         = rv_q;
  assign resp_rdata         = rdat_q;
  assign resp_corrected     = corr_q;
  assign resp_uncorrectable = unc_q;
endmodule

// File: rtl/rowsum_parity_ctrl_chk.sv
module rowsum_parity_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic req_write,
  input logic resp_valid,
  input logic resp_corrected,
  input logic resp_uncorrectable
);
  logic acc_rd, acc_wr;
  assign acc_rd = req_valid && req_ready && !req_write;
  assign acc_wr = req_valid && req_ready && req_write;

  // R5
  a_r5_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R5
  a_r5_resp_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> req_ready);
  // R5
  a_r5_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);
  // R10
  a_r10_flags_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_valid |-> !(resp_corrected || resp_uncorrectable));
  // R10
  a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !(resp_corrected && resp_uncorrectable));
  // R4
  a_r4_write_latency: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr |=> !resp_valid ##1 !resp_valid ##1 !resp_valid
               ##1 (resp_valid && !resp_corrected && !resp_uncorrectable));
  // R3
  a_r3_read_first_step: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> !resp_valid ##1 (resp_valid || !req_ready));
endmodule

bind rowsum_parity_ctrl rowsum_parity_ctrl_chk u_chk (
  .clk                (clk),
  .rst_n              (rst_n),
  .req_valid          (req_valid),
  .req_ready          (req_ready),
  .req_write          (req_write),
  .resp_valid         (resp_valid),
  .resp_corrected     (resp_corrected),
  .resp_uncorrectable (resp_uncorrectable)
);

// File: tb/rowsum_parity_ctrl_test.sv
module rowsum_parity_ctrl_test;
  localparam int CHIPS = 4;
  localparam int ROWS  = 8;
  localparam int LINES = CHIPS * ROWS;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [4:0]  req_addr;
  logic [15:0] req_wdata;
  logic        resp_valid, resp_corrected, resp_uncorrectable;
  logic [15:0] resp_rdata;
  logic        inj_valid;
  logic [2:0]  inj_chip;
  logic [2:0]  inj_row;
  logic [15:0] inj_mask;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [15:0] exp_mem [LINES];

  always #2 clk = ~clk;

  rowsum_parity_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .resp_corrected(resp_corrected), .resp_uncorrectable(resp_uncorrectable),
    .inj_valid(inj_valid), .inj_chip(inj_chip), .inj_row(inj_row), .inj_mask(inj_mask)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic xact(input bit wr, input logic [4:0] a, input logic [15:0] d,
                      output logic [15:0] rd, output bit co, output bit un,
                      output int lat);
    bit busy_bad;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    busy_bad = 1'b0;
    do begin
      if (req_ready) busy_bad = 1'b1;
      @(posedge clk);
      lat++;
      @(negedge clk);
    end while (!resp_valid && lat < 40);
    chk(!busy_bad, "R5", "ready high while busy", 32'(busy_bad), 0);
    chk(req_ready, "R5", "ready at response", 32'(req_ready), 1);
    rd = resp_rdata; co = resp_corrected; un = resp_uncorrectable;
  endtask

  task automatic inject(input int chip, input int row, input logic [15:0] m);
    @(negedge clk);
    inj_valid = 1'b1; inj_chip = 3'(chip); inj_row = 3'(row); inj_mask = m;
    @(posedge clk);
    @(negedge clk);
    inj_valid = 1'b0;
  endtask

  function automatic logic [15:0] slice_mask(input int a);
    int sl = (a + a / 4) % 4;
    logic [15:0] nib = 16'((a % 15) + 1);
    return nib << (4 * sl);
  endfunction

  task automatic wr_line(input int a, input logic [15:0] d);
    logic [15:0] rd; bit co, un; int lat;
    xact(1'b1, 5'(a), d, rd, co, un, lat);
    chk(lat == 3, "R4", "write latency", 32'(lat), 3);
    chk(!co && !un, "R4", "write flags", {co, un}, 0);
    exp_mem[a] = d;
  endtask

  task automatic rd_clean(input int a, input string req);
    logic [15:0] rd; bit co, un; int lat;
    xact(1'b0, 5'(a), 16'h0, rd, co, un, lat);
    chk(rd == exp_mem[a], req, "clean read data", 32'(rd), 32'(exp_mem[a]));
    chk(lat == 1, "R3", "clean read latency", 32'(lat), 1);
    chk(!co && !un, "R3", "clean read flags", {co, un}, 0);
  endtask

  task automatic sweep(input string req);
    logic [15:0] rd; bit co, un; int lat;
    for (int a = 0; a < LINES; a++) begin
      inject(a % CHIPS, a / CHIPS, slice_mask(a));
      for (int k = 0; k < 2; k++) begin
        xact(1'b0, 5'(a), 16'h0, rd, co, un, lat);
        chk(rd == exp_mem[a], req, "rebuilt data", 32'(rd), 32'(exp_mem[a]));
        chk(co && !un, "R6", "detect and correct flags", {co, un}, 2);
        chk(lat == CHIPS + 2, "R7", "rebuild latency", 32'(lat), CHIPS + 2);
        if (k == 1) chk(co, "R12", "still damaged on second read", 32'(co), 1);
      end
      inject(a % CHIPS, a / CHIPS, slice_mask(a));
      rd_clean(a, "R11");
    end
  endtask

  initial begin
    logic [15:0] lf;
    logic [15:0] rd; bit co, un; int lat;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    inj_valid = 1'b0; inj_chip = '0; inj_row = '0; inj_mask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 1);
    chk(resp_valid == 1'b0, "R1", "resp_valid after reset", 32'(resp_valid), 0);
    for (int a = 0; a < LINES; a++) begin
      exp_mem[a] = 16'h0;
      rd_clean(a, "R1");
    end

    // R2/R4: fill every line with a distinct value, then read all back
    for (int a = 0; a < LINES; a++) wr_line(a, 16'(a * 40503) ^ 16'h3c5a);
    for (int a = 0; a < LINES; a++) rd_clean(a, "R2");

    // R6/R7/R12: single-slice corruption of each line in turn
    sweep("R7");

    // random writes, then parity consistency through rebuilds (R9)
    lf = 16'hace1;
    for (int n = 0; n < 300; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      wr_line(int'(lf[4:0]), lf ^ 16'(n * 7));
    end
    sweep("R9");
    for (int a = 0; a < LINES; a++) rd_clean(a, "R9");

    // R11 / R8
    for (int r = 0; r < ROWS; r++) begin
      inject(CHIPS, r, 16'h0300);
      for (int c = 0; c < CHIPS; c++) rd_clean(r * CHIPS + c, "R11");
      for (int c = 0; c < CHIPS; c++) begin
        inject(c, r, 16'h0001);
        xact(1'b0, 5'(r * CHIPS + c), 16'h0, rd, co, un, lat);
        chk(un && !co, "R8", "parity also bad", {co, un}, 1);
        chk(lat == CHIPS + 2, "R8", "uncorrectable latency", 32'(lat), CHIPS + 2);
        inject(c, r, 16'h0001);
      end
      inject(CHIPS, r, 16'h0300);
      inject(0, r, 16'h00a0);
      inject(1, r, 16'h5000);
      xact(1'b0, 5'(r * CHIPS), 16'h0, rd, co, un, lat);
      chk(un && !co, "R8", "second data chip bad", {co, un}, 1);
      inject(0, r, 16'h00a0);
      inject(1, r, 16'h5000);
      rd_clean(r * CHIPS, "R8");
      rd_clean(r * CHIPS + 1, "R8");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule